// File: doc/BRIEF.md
# Dual-Personality Floppy Controller Register Front-End

This block is the register face of a floppy disk controller that comes out of reset speaking a legacy soft-switch protocol and can be moved, by a fixed run of four writes, into a richer register personality. It sits on a byte-wide bus. The register slot is taken from a 4-bit field of the address, so sixteen slots are spread across an 8 KB window and the address bits below the field carry no meaning.

In the legacy personality, any access (read or write) flips one of eight one-bit soft switches. These are four stepper phases, motor, drive select and two mode-control switches, named Q6 and Q7 here. The slot number picks the switch and its lowest bit gives the value. A write made while both mode-control switches are set lands in a data holding register when the motor switch is on, and in a mode holding register when it is off. Values written to the mode holding register are watched by an unlock detector. In the richer personality the switches freeze. The block then offers a phase register, a mode register with separate bit-set and bit-clear write slots, and a handshake status that reports "no drive present" for one specific phase value.

Top module: `fdc_regfront`

## Requirements
- R1: After a synchronous active-low reset, `native_mode` is 0, all eight switch outputs are 0, `ctrl_mode` is 0, the phase register is 0 and the unlock progress is cleared.
- R2: While `native_mode` is 0, each clock edge with `bus_rd` or `bus_wr` high updates switch `slot>>1` to `slot[0]`, where `slot` is `bus_addr[12:9]`. Address bits [8:0] are ignored. Switch order on `sw_latch` is bit0..3 = phases 0..3, bit4 = motor, bit5 = drive select, bit6 = Q6, bit7 = Q7.
- R3: While `native_mode` is 0, `bus_rdata` is 0.
- R4: In the legacy personality, a write with Q6, Q7 set and motor clear goes to the mode holding register. Q6, Q7 and motor are taken with the update made by that same access. The detector expects 0x57, 0x17, 0x57, 0x57 in that order. A non-matching value leaves its progress unchanged. The fourth match sets `native_mode` at that clock edge and clears the progress.
- R5: A legacy write made while the motor switch is set goes to the data holding register and does not advance the unlock detector.
- R6: A legacy write made while Q6 or Q7 is clear reaches neither holding register and does not advance the unlock detector.
- R7: In the native personality, a write to slot 4 loads the phase register, and a read of slot 12 returns its value.
- R8: In the native personality, a write to slot 6 clears every `ctrl_mode` bit that is 1 in the write data. A write to slot 7 sets every such bit.
- R9: In the native personality, a read of slot 15 returns 0x08 when the phase register holds 0x77, and 0 otherwise.
- R10: In the native personality, writes to slots 0-3 and 5 change nothing, reads of slots 0-11, 13 and 14 return 0, and no access changes `sw_latch`.
- R11: `native_mode` stays 1 until reset. The first access after the unlock is already decoded by the native personality.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 13 | Byte address inside the 8 KB window; slot is bits [12:9] |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current slot and state |
| native_mode | output | 1 | 1 once the richer personality is active |
| sw_latch | output | 8 | Legacy soft-switch states |
| ctrl_mode | output | 8 | Native mode register |

## Verification
The hardest state to reach is the unlock. It needs Q6 and Q7 set and the motor clear at the moment each of four specific values is written. Every one of those writes also moves a switch, and a wrong slot silently steers the value away from the detector. The stimulus first opens the write path with a read of the Q6-high slot. It then writes the sequence through the Q7-high slot, so that the same access sets Q7 and delivers the value. Non-matching values are placed between the matches, and the same values are repeated with the motor on and with Q6 off, to show that only the correct path advances the detector.

// File: rtl/fdc_regfront_pkg.sv
// Package: shared constants and types for the floppy register front-end.
// Assumes an 8-bit data bus and a 4-bit slot field.
package fdc_regfront_pkg;

    // Which register personality is active.
    typedef enum logic {
        PERS_LEGACY = 1'b0,
        PERS_NATIVE = 1'b1
    } pers_e;

    localparam int SLOT_W = 4;
    typedef logic [SLOT_W-1:0] slot_t;

    // Soft-switch positions whose values steer legacy writes.
    localparam int SW_MOTOR = 4;
    localparam int SW_Q6    = 6;
    localparam int SW_Q7    = 7;

    // Native write slots.
    localparam slot_t WS_PHASE = 4'd4;
    localparam slot_t WS_MCLR  = 4'd6;
    localparam slot_t WS_MSET  = 4'd7;

    // Native read slots.
    localparam slot_t RS_PHASE = 4'd12;
    localparam slot_t RS_HSHK  = 4'd15;

    // Handshake sense bit and the phase value that asks for drive presence.
    localparam logic [7:0] HS_SENSE      = 8'h08;
    localparam logic [7:0] PH_ASK_DRIVE  = 8'h77;

    // Unlock sequence values.
    localparam logic [7:0] UNLOCK_OUTER = 8'h57;
    localparam logic [7:0] UNLOCK_INNER = 8'h17;

endpackage

// File: rtl/fdc_soft_latches.sv
// Module: fdc_soft_latches
// Legacy personality. Keeps the address-toggled soft switches and the
// data and mode holding registers. A write is steered by the switch values
// that include the update made by that same access.
// Assumes acc_en is only high while the legacy personality is active.
module fdc_soft_latches
    import fdc_regfront_pkg::*;
#(
    parameter int SLOT_BITS = SLOT_W,
    parameter int DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_en,
    input  logic                 wr_en,
    input  logic [SLOT_BITS-1:0] slot,
    input  logic [DATA_W-1:0]    wdata,
    output logic [(1<<(SLOT_BITS-1))-1:0] sw_q,
    output logic [DATA_W-1:0]    hold_data_q,
    output logic [DATA_W-1:0]    hold_mode_q,
    output logic                 mode_wr
);
    localparam int N_SW = 1 << (SLOT_BITS - 1);

    logic [N_SW-1:0] sw_nxt;
    logic            data_wr;

    // Next switch values after the current access.
    always_comb begin
        sw_nxt = sw_q;
        if (acc_en) begin
            sw_nxt[slot[SLOT_BITS-1:1]] = slot[0];
        end
    end

    // Steer a write with Q6 and Q7 set to the data or mode holding register.
    always_comb begin
        data_wr = acc_en && wr_en && sw_nxt[SW_Q6] && sw_nxt[SW_Q7] &&  sw_nxt[SW_MOTOR];
        mode_wr = acc_en && wr_en && sw_nxt[SW_Q6] && sw_nxt[SW_Q7] && !sw_nxt[SW_MOTOR];
    end

    // One flop per switch, each updated when its own pair of slots is hit.
    for (genvar g = 0; g < N_SW; g++) begin : g_sw
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sw_q[g] <= 1'b0;
            end else if (acc_en && (slot[SLOT_BITS-1:1] == g)) begin
                sw_q[g] <= slot[0];
            end
        end
    end

    // Data holding register load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data_q <= '0;
        end else if (data_wr) begin
            hold_data_q <= wdata;
        end
    end

    // Mode holding register load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_mode_q <= '0;
        end else if (mode_wr) begin
            hold_mode_q <= wdata;
        end
    end

    // R2: the addressed switch takes the slot's low bit.
    p_switch_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> (sw_q[$past(slot[SLOT_BITS-1:1])] == $past(slot[0])));

    // R6: a write with Q6 or Q7 ending up clear loads no holding register.
    p_gate_closed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && wr_en && !(sw_nxt[SW_Q6] && sw_nxt[SW_Q7]))
            |=> ($stable(hold_mode_q) && $stable(hold_data_q)));

    // R5: a write with the motor on leaves the mode holding register alone.
    p_motor_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr) |=> $stable(hold_mode_q));

    // R10: with no legacy access, the switches hold.
    p_switch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> $stable(sw_q));

endmodule

// File: rtl/fdc_unlock_seq.sv
// Module: fdc_unlock_seq
// Watches values written to the legacy mode holding register. It moves to
// the native personality after the fixed four-value sequence. A
// non-matching value holds progress. The native personality stays until reset.
module fdc_unlock_seq
    import fdc_regfront_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STEPS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [DATA_W-1:0] wdata,
    output pers_e             pers
);
    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

    logic [STEP_W-1:0] step_q;
    logic [DATA_W-1:0] want;
    logic              hit;

    // Expected value for the current step: the inner value at step 1 only.
    always_comb begin
        want = (step_q == STEP_W'(1)) ? DATA_W'(UNLOCK_INNER) : DATA_W'(UNLOCK_OUTER);
        hit  = mode_wr && (wdata == want) && (pers == PERS_LEGACY);
    end

    // Progress counter and personality flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            pers   <= PERS_LEGACY;
        end else if (hit) begin
            if (step_q == LAST) begin
                step_q <= '0;
                pers   <= PERS_NATIVE;
            end else begin
                step_q <= step_q + STEP_W'(1);
            end
        end
    end

    // R4: a mismatching value keeps the progress where it is.
    p_step_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && (wdata != want)) |=> $stable(step_q));

    // R4: the switch happens only from the last step on a matching write.
    p_switch_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pers == PERS_LEGACY && !(hit && step_q == LAST)) |=> (pers == PERS_LEGACY));

    // R11: the native personality is sticky.
    p_native_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pers == PERS_NATIVE) |=> (pers == PERS_NATIVE));

endmodule

// File: rtl/fdc_native_regs.sv
// Module: fdc_native_regs
// Native personality. Holds the phase register and the mode register with
// bit-clear and bit-set write slots, and builds the read data.
// Assumes en is high only while the native personality is active.
module fdc_native_regs
    import fdc_regfront_pkg::*;
#(
    parameter int SLOT_BITS = SLOT_W,
    parameter int DATA_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 rd,
    input  logic                 wr,
    input  logic [SLOT_BITS-1:0] slot,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    phase_q,
    output logic [DATA_W-1:0]    mode_q,
    output logic [DATA_W-1:0]    rdata
);
    logic wr_phase, wr_clr, wr_set;

    // Write slot decode.
    always_comb begin
        wr_phase = en && wr && (slot == SLOT_BITS'(WS_PHASE));
        wr_clr   = en && wr && (slot == SLOT_BITS'(WS_MCLR));
        wr_set   = en && wr && (slot == SLOT_BITS'(WS_MSET));
    end

    // Phase register load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (wr_phase) begin
            phase_q <= wdata;
        end
    end

    // Mode register bit-clear and bit-set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_clr) begin
            mode_q <= mode_q & ~wdata;
        end else if (wr_set) begin
            mode_q <= mode_q | wdata;
        end
    end

    // Read mux; unimplemented slots read as zero.
    always_comb begin
        rdata = '0;
        if (en && rd) begin
            if (slot == SLOT_BITS'(RS_PHASE)) begin
                rdata = phase_q;
            end else if (slot == SLOT_BITS'(RS_HSHK)) begin
                rdata = (phase_q == DATA_W'(PH_ASK_DRIVE)) ? DATA_W'(HS_SENSE) : '0;
            end
        end
    end

    // R8: after a set write every written 1 is present.
    p_mode_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mode_q & $past(wdata)) == $past(wdata)));

    // R8: after a clear write every written 1 is gone.
    p_mode_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mode_q & $past(wdata)) == '0));

    // R10: any write outside slots 4, 6 and 7 leaves both registers unchanged.
    p_ignored_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_phase && !wr_clr && !wr_set) |=> ($stable(phase_q) && $stable(mode_q)));

endmodule

// File: rtl/fdc_regfront.sv
// Module: fdc_regfront (top)
// Dual-personality floppy register front-end. It takes the slot from the
// address field, routes accesses to the legacy switches or the native
// registers, and exposes the personality and register states.
// Assumes strobes are single-cycle and the reset is synchronous.
module fdc_regfront
    import fdc_regfront_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int SLOT_LSB = 9,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              native_mode,
    output logic [7:0]        sw_latch,
    output logic [DATA_W-1:0] ctrl_mode
);
    localparam int SLOT_BITS = ADDR_W - SLOT_LSB;
    localparam int N_SW      = 1 << (SLOT_BITS - 1);

    logic [SLOT_BITS-1:0] slot;
    pers_e                pers;
    logic                 legacy_acc;
    logic                 mode_wr;
    logic [N_SW-1:0]      sw_q;
    logic [DATA_W-1:0]    hold_data_q, hold_mode_q;
    logic [DATA_W-1:0]    phase_q, nat_rdata;

    // Slot field extraction and legacy access qualifier.
    always_comb begin
        slot       = bus_addr[ADDR_W-1:SLOT_LSB];
        legacy_acc = (pers == PERS_LEGACY) && (bus_rd || bus_wr);
    end

    fdc_soft_latches #(
        .SLOT_BITS (SLOT_BITS),
        .DATA_W    (DATA_W)
    ) u_sw (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_en      (legacy_acc),
        .wr_en       (bus_wr),
        .slot        (slot),
        .wdata       (bus_wdata),
        .sw_q        (sw_q),
        .hold_data_q (hold_data_q),
        .hold_mode_q (hold_mode_q),
        .mode_wr     (mode_wr)
    );

    fdc_unlock_seq #(
        .DATA_W (DATA_W),
        .STEPS  (4)
    ) u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_wr),
        .wdata   (bus_wdata),
        .pers    (pers)
    );

    fdc_native_regs #(
        .SLOT_BITS (SLOT_BITS),
        .DATA_W    (DATA_W)
    ) u_nat (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (pers == PERS_NATIVE),
        .rd      (bus_rd),
        .wr      (bus_wr),
        .slot    (slot),
        .wdata   (bus_wdata),
        .phase_q (phase_q),
        .mode_q  (ctrl_mode),
        .rdata   (nat_rdata)
    );

    // Output assembly: legacy reads return zero.
    always_comb begin
        native_mode = (pers == PERS_NATIVE);
        sw_latch    = 8'(sw_q);
        bus_rdata   = native_mode ? nat_rdata : '0;
    end

    // R3: legacy reads are always zero.
    p_legacy_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!native_mode && bus_rd) |-> (bus_rdata == '0));

    // R10: the switches are frozen in the native personality.
    p_native_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        native_mode |=> $stable(sw_latch));

endmodule

// File: tb/fdc_regfront_tb_top.sv
// Directed bench for fdc_regfront: one task per scenario.
module fdc_regfront_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        native_mode;
    logic [7:0]  sw_latch;
    logic [7:0]  ctrl_mode;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdc_regfront dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .native_mode (native_mode),
        .sw_latch    (sw_latch),
        .ctrl_mode   (ctrl_mode)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One bus access; the read data is sampled mid-low-phase, before the edge.
    task automatic bus_op(input logic [3:0] slot, input logic [8:0] low,
                          input logic rd, input logic wr, input logic [7:0] d,
                          output logic [7:0] q);
        @(negedge clk);
        bus_addr  = {slot, low};
        bus_rd    = rd;
        bus_wr    = wr;
        bus_wdata = d;
        #(CLK_PERIOD/4);
        q = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        bus_wr = 1'b0;
    endtask

    task automatic wr_slot(input logic [3:0] slot, input logic [7:0] d);
        logic [7:0] q;
        bus_op(slot, 9'h0A5, 1'b0, 1'b1, d, q);
    endtask

    task automatic rd_slot(input logic [3:0] slot, output logic [7:0] q);
        bus_op(slot, 9'h15A, 1'b1, 1'b0, 8'h00, q);
    endtask

    task automatic unlock();
        logic [7:0] q;
        rd_slot(4'd8, q);   // motor off
        rd_slot(4'd13, q);  // Q6 on
        wr_slot(4'd15, 8'h57);
        wr_slot(4'd15, 8'h17);
        wr_slot(4'd15, 8'h57);
        wr_slot(4'd15, 8'h57);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 native_mode", {7'd0, native_mode}, 8'h00);
        check("R1 sw_latch", sw_latch, 8'h00);
        check("R1 ctrl_mode", ctrl_mode, 8'h00);
    endtask

    task automatic t_switches();
        logic [7:0] model = 8'h00;
        logic [7:0] q;
        do_reset();
        for (int n = 0; n < 16; n++) begin
            if (n % 2 == 0) rd_slot(4'(n ^ 1), q); else wr_slot(4'(n ^ 1), 8'h00);
            model[(n ^ 1) >> 1] = (n ^ 1) & 1;
            check("R2 switch after access", sw_latch, model);
            check("R3 legacy read zero", q, 8'h00);
        end
        bus_op(4'd1, 9'h1FF, 1'b1, 1'b0, 8'h00, q);
        model[0] = 1'b1;
        check("R2 low addr ignored", sw_latch, model);
        check("R3 legacy read zero", q, 8'h00);
        check("R6 writes without Q6 not steered", {7'd0, native_mode}, 8'h00);
    endtask

    task automatic t_unlock_paths();
        logic [7:0] q;
        do_reset();
        // Q6 and Q7 clear: sequence written to Q7-low slot reaches nothing.
        for (int i = 0; i < 4; i++) wr_slot(4'd14, (i == 1) ? 8'h17 : 8'h57);
        check("R6 gate closed keeps legacy", {7'd0, native_mode}, 8'h00);
        // Motor on: values go to the data holding register.
        rd_slot(4'd9, q);
        rd_slot(4'd13, q);
        wr_slot(4'd15, 8'h57); wr_slot(4'd15, 8'h17);
        wr_slot(4'd15, 8'h57); wr_slot(4'd15, 8'h57);
        check("R5 motor on keeps legacy", {7'd0, native_mode}, 8'h00);
        check("R5 switches", sw_latch, 8'hD0);
        // Motor off: sequence with noise.
        rd_slot(4'd8, q);
        wr_slot(4'd15, 8'h57);
        wr_slot(4'd15, 8'h33);
        wr_slot(4'd15, 8'h17);
        wr_slot(4'd15, 8'h57);
        check("R4 three matches stay legacy", {7'd0, native_mode}, 8'h00);
        wr_slot(4'd15, 8'h57);
        check("R4 fourth match unlocks", {7'd0, native_mode}, 8'h01);
        check("R11 switches frozen", sw_latch, 8'hC0);
    endtask

    task automatic t_native();
        logic [7:0] q;
        do_reset();
        unlock();
        check("R4 unlocked", {7'd0, native_mode}, 8'h01);
        wr_slot(4'd4, 8'h5A);
        rd_slot(4'd12, q);
        check("R11 first access native", q, 8'h5A);
        check("R7 phase readback", q, 8'h5A);
        rd_slot(4'd15, q);
        check("R9 handshake other", q, 8'h00);
        wr_slot(4'd4, 8'h77);
        rd_slot(4'd15, q);
        check("R9 handshake sense", q, 8'h08);
        wr_slot(4'd4, 8'h76);
        rd_slot(4'd15, q);
        check("R9 handshake near value", q, 8'h00);
        wr_slot(4'd7, 8'hF0);
        check("R8 set", ctrl_mode, 8'hF0);
        wr_slot(4'd7, 8'h0F);
        check("R8 set more", ctrl_mode, 8'hFF);
        wr_slot(4'd6, 8'h3C);
        check("R8 clear", ctrl_mode, 8'hC3);
        foreach (q[i]) begin end
        wr_slot(4'd0, 8'hAA); wr_slot(4'd1, 8'hAA); wr_slot(4'd2, 8'hAA);
        wr_slot(4'd3, 8'hAA); wr_slot(4'd5, 8'hAA);
        check("R10 ignored writes mode", ctrl_mode, 8'hC3);
        rd_slot(4'd12, q);
        check("R10 ignored writes phase", q, 8'h76);
        for (int s = 0; s < 15; s++) begin
            if (s != 12) begin
                rd_slot(4'(s), q);
                check("R10 unimplemented read", q, 8'h00);
            end
        end
        check("R10 switches frozen", sw_latch, 8'hC0);
        wr_slot(4'd14, 8'h57);
        check("R11 sticky", {7'd0, native_mode}, 8'h01);
        do_reset();
        check("R1 reset to legacy", {7'd0, native_mode}, 8'h00);
        check("R1 mode cleared", ctrl_mode, 8'h00);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_switches();
                t_unlock_paths();
                t_native();
            end
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule